// File: doc/BRIEF.md
# SPI Serial EEPROM Command Engine

This block is the slave side of a serial EEPROM reached over SPI. A host selects it, clocks in a one-byte opcode, a 24-bit address and, for writes, data bytes, and clocks read data or the status byte back out. The storage is a small synthesizable byte array. A programmed page is committed from a page buffer, and a self-timed busy period follows, counted in system clocks.

The SPI pins are not used as clocks. Chip select, serial clock, data in and hold pass through two-flop synchronisers into the faster system clock, and serial-clock edges are detected there. The serial clock must therefore stay at each level for at least four system clocks. A hold input pauses a transfer part-way and releases the output.

Opcodes: 0x06 sets the write-enable latch, 0x04 clears it, 0x05 reads status, 0x01 writes status, 0x03 reads the array and 0x02 writes the array. Status byte layout: bit 0 busy, bit 1 write-enable latch, bits 2, 3 and 7 user-writable protection bits, and bits 4 to 6 read as zero.

Top module: `spi_eeprom`

## Requirements
- R1: Bits move most significant first. Input is sampled on serial-clock rising edges, and the output bit changes only after a falling edge.
- R2: Transfers behave identically with the clock idling low (mode 0) and idling high (mode 3) while deselected.
- R3: After an opcode not in the set 0x06/0x04/0x05/0x01/0x03/0x02, every further byte is ignored until chip select rises. The output stays undriven.
- R4: Read and write take three address bytes after the opcode. Only the low ADDR_W bits of the 24-bit value select a location.
- R5: A read returns consecutive bytes from incrementing addresses. After the last location it continues at address 0, for as long as chip select stays low.
- R6: A write is committed only when chip select rises with at least one whole data byte received and no partial byte pending. Otherwise nothing changes, no busy period starts, and the write-enable latch keeps its value.
- R7: Within one write, the low PAGE_W address bits wrap inside the addressed page. A later byte to the same location overwrites an earlier one.
- R8: Array and status writes are ignored unless the write-enable latch (status bit 1) is set. The latch is set by 0x06 and cleared by 0x04 and at the end of every busy period. Status reads 0x00 after reset.
- R9: A committed write sets status bit 0 for WR_TICKS system clocks. During that time every opcode except 0x05 is ignored.
- R10: Hold starts when the hold input is low while the clock is low, and ends when it is high while the clock is low. While held, the output enable is low and clock edges are ignored, so the transfer resumes intact.
- R11: A status write, sent as 0x01 followed by a data byte, stores only bits 7, 3 and 2 of that byte. These bits appear at the same positions in the status byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_sck | input | 1 | Serial clock |
| spi_mosi | input | 1 | Serial data into the block |
| spi_hold_n | input | 1 | Active-low transfer pause |
| spi_miso | output | 1 | Serial data out of the block |
| spi_miso_oe | output | 1 | High when spi_miso should be driven onto the bus |

## Verification
Every page of a reduced array is filled by page writes, alternating between mode 0 and mode 3. One mode-3 read then streams the whole array from near the top, through the wrap, using an address with junk upper bits. A mismatch there separates address truncation, increment and wrap faults from write-path faults. Three targeted writes follow: one that runs past the end of a page, one cut mid-byte, and one with no data. These separate the page-offset wrap from the byte-boundary commit rule. Writes and opcodes sent during busy, an unknown opcode followed by a valid-looking one, status writes, and a read paused mid-byte by hold show whether ignored traffic really leaves the state untouched.

// File: rtl/spi_eeprom.sv
module spi_eeprom #(
  parameter int ADDR_W   = 10,
  parameter int PAGE_W   = 8,
  parameter int WR_TICKS = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_cs_n,
  input  logic spi_sck,
  input  logic spi_mosi,
  input  logic spi_hold_n,
  output logic spi_miso,
  output logic spi_miso_oe
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAGE  = 1 << PAGE_W;
  localparam int TW    = $clog2(WR_TICKS + 1);
  localparam logic [ADDR_W-1:0] PMASK = ADDR_W'(PAGE - 1);
  localparam logic [7:0] OP_WREN = 8'h06, OP_WRDI = 8'h04, OP_RDSR = 8'h05,
                         OP_WRSR = 8'h01, OP_READ = 8'h03, OP_WRITE = 8'h02;

  typedef enum logic [2:0] {S_OP, S_ADR, S_RD, S_WR, S_RS, S_WS, S_IGN} st_t;

  logic [2:0] cs_p, sck_p;
  logic [1:0] mosi_p, hold_p;
  logic cs_s, held, rise, fall, cs_rise, byte_done;
  st_t st;
  logic [2:0] cnt;
  logic [6:0] sr;
  logic [1:0] ab;
  logic is_wr, load, got, wel, busy;
  logic [ADDR_W-1:0] addr;
  logic [7:0] out_sr, byte_in, status, rd_byte;
  logic [2:0] prot, ws_pend;
  logic [TW-1:0] tmr;
  logic [PAGE-1:0] vld;
  logic commit_arr, commit_st, wr_go, in_ign;
  logic [7:0] mem  [DEPTH];
  logic [7:0] pbuf [PAGE];

  assign cs_s       = cs_p[1];
  assign cs_rise    = cs_p[1] & ~cs_p[2];
  assign rise       = sck_p[1] & ~sck_p[2] & ~held & ~cs_s;
  assign fall       = ~sck_p[1] & sck_p[2] & ~held & ~cs_s;
  assign byte_in    = {sr, mosi_p[1]};
  assign byte_done  = rise & (cnt == 3'd7);
  assign commit_arr = cs_rise & (st == S_WR) & got & (cnt == 3'd0);
  assign commit_st  = cs_rise & (st == S_WS) & got & (cnt == 3'd0);
  assign wr_go      = commit_arr | commit_st;
  assign in_ign     = (st == S_IGN);
  assign status     = {prot[2], 3'b000, prot[1:0], wel, busy};
  assign rd_byte    = (st == S_RS) ? status : mem[addr];
  assign spi_miso    = out_sr[7];
  assign spi_miso_oe = ~cs_s & ~held & ((st == S_RD) | (st == S_RS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_p <= 3'b111; sck_p <= '0; mosi_p <= '0; hold_p <= 2'b11; held <= 1'b0;
    end else begin
      cs_p   <= {cs_p[1:0], spi_cs_n};
      sck_p  <= {sck_p[1:0], spi_sck};
      mosi_p <= {mosi_p[0], spi_mosi};
      hold_p <= {hold_p[0], spi_hold_n};
      if (cs_s)                               held <= 1'b0;
      else if (!held && !hold_p[1] && !sck_p[1]) held <= 1'b1;
      else if (held && hold_p[1] && !sck_p[1])   held <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_OP; cnt <= '0; sr <= '0; ab <= '0; is_wr <= 1'b0; load <= 1'b0;
      got <= 1'b0; wel <= 1'b0; busy <= 1'b0; addr <= '0; out_sr <= '0;
      prot <= '0; ws_pend <= '0; tmr <= '0; vld <= '0;
    end else begin
      if (busy) begin
        tmr <= tmr - TW'(1);
        if (tmr == TW'(1)) begin busy <= 1'b0; wel <= 1'b0; end
      end
      if (cs_s) begin
        st <= S_OP; cnt <= '0; load <= 1'b0; got <= 1'b0; ab <= '0;
        if (wr_go) begin busy <= 1'b1; tmr <= TW'(WR_TICKS); end
        if (commit_st) prot <= ws_pend;
      end else begin
        if (rise) begin sr <= byte_in[6:0]; cnt <= cnt + 3'd1; end
        if (fall) begin
          out_sr <= load ? rd_byte : {out_sr[6:0], 1'b0};
          if (load) begin
            load <= 1'b0;
            if (st == S_RD) addr <= addr + ADDR_W'(1);
          end
        end
        if (byte_done) begin
          case (st)
            S_OP:
              if (busy && byte_in != OP_RDSR) st <= S_IGN;
              else case (byte_in)
                OP_WREN:  begin wel <= 1'b1; st <= S_IGN; end
                OP_WRDI:  begin wel <= 1'b0; st <= S_IGN; end
                OP_RDSR:  begin st <= S_RS; load <= 1'b1; end
                OP_WRSR:  st <= wel ? S_WS : S_IGN;
                OP_READ:  begin st <= S_ADR; is_wr <= 1'b0; end
                OP_WRITE: begin st <= wel ? S_ADR : S_IGN; is_wr <= 1'b1; end
                default:  st <= S_IGN;
              endcase
            S_ADR: begin
              addr <= ADDR_W'({addr, byte_in});
              ab   <= ab + 2'd1;
              if (ab == 2'd2) begin
                if (is_wr) begin st <= S_WR; vld <= '0; end
                else begin st <= S_RD; load <= 1'b1; end
              end
            end
            S_WR: begin
              vld[addr[PAGE_W-1:0]] <= 1'b1;
              addr <= (addr & ~PMASK) | ((addr + ADDR_W'(1)) & PMASK);
              got  <= 1'b1;
            end
            S_WS: begin ws_pend <= {byte_in[7], byte_in[3:2]}; got <= 1'b1; end
            S_RS, S_RD: load <= 1'b1;
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (byte_done && st == S_WR) pbuf[addr[PAGE_W-1:0]] <= byte_in;
    if (commit_arr)
      for (int i = 0; i < PAGE; i++)
        if (vld[i]) mem[(addr & ~PMASK) | ADDR_W'(i)] <= pbuf[i];
  end
endmodule

module spi_eeprom_chk (
  input logic clk,
  input logic rst_n,
  input logic spi_miso,
  input logic spi_miso_oe,
  input logic held,
  input logic busy,
  input logic wel,
  input logic ign,
  input logic cs_s,
  input logic fall,
  input logic commit
);
  a_r1_miso_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !fall |=> $stable(spi_miso));
  a_r10_held_not_driving: assert property (@(posedge clk) disable iff (!rst_n)
    held |-> !spi_miso_oe);
  a_r9_no_commit_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !commit);
  a_r8_latch_clear_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !wel);
  a_r3_ignore_until_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    (ign && !cs_s) |=> ign);
  a_r3_ignore_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    ign |-> !spi_miso_oe);
endmodule

bind spi_eeprom spi_eeprom_chk u_chk (
  .clk(clk), .rst_n(rst_n), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
  .held(held), .busy(busy), .wel(wel), .ign(in_ign), .cs_s(cs_s),
  .fall(fall), .commit(wr_go)
);

// File: tb/spi_eeprom_test.sv
module spi_eeprom_test;
  localparam int AW = 9, PW = 4, TICKS = 600, HALF = 4;
  localparam int NB = 1 << AW, PG = 1 << PW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, hold_n = 1'b1;
  logic miso, miso_oe;
  int n_chk = 0, n_fail = 0;
  bit mode3 = 1'b0;
  logic [7:0] ref_mem [NB];
  logic [7:0] wbuf [32];

  always #10 clk = ~clk;

  spi_eeprom #(.ADDR_W(AW), .PAGE_W(PW), .WR_TICKS(TICKS)) uut (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck), .spi_mosi(mosi),
    .spi_hold_n(hold_n), .spi_miso(miso), .spi_miso_oe(miso_oe));

  function automatic logic [7:0] pat(int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  task automatic tick(int n); repeat (n) @(negedge clk); endtask

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sel(); sck = mode3; tick(2); cs_n = 1'b0; tick(HALF); endtask
  task automatic desel(); sck = mode3; tick(HALF); cs_n = 1'b1; tick(10); endtask

  task automatic xbit(input bit b, output bit r);
    sck = 1'b0; mosi = b; tick(HALF); r = miso; sck = 1'b1; tick(HALF);
  endtask

  task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      bit r;
      xbit(tx[i], r);
      rx[i] = r;
    end
  endtask

  task automatic cmd(input logic [7:0] op);
    logic [7:0] d;
    sel(); xbyte(op, d); desel();
  endtask

  task automatic rdsr(output logic [7:0] s);
    logic [7:0] d;
    sel(); xbyte(8'h05, d); xbyte(8'h00, s); desel();
  endtask

  task automatic send_addr(input int a);
    logic [7:0] d;
    xbyte(8'hC3, d);
    xbyte({7'h7F, 1'(a >> 8)}, d);
    xbyte(8'(a), d);
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int k = 0; k < 20; k++) begin
      rdsr(s);
      if (!s[0]) break;
    end
    chk(s[0] == 1'b0, "R9 busy ends", s, 0);
  endtask

  task automatic wr(input int a, input int n, input bit model);
    logic [7:0] d;
    sel(); xbyte(8'h02, d); send_addr(a);
    for (int i = 0; i < n; i++) begin
      xbyte(wbuf[i], d);
      if (model) ref_mem[(a & ~(PG - 1)) | ((a + i) & (PG - 1))] = wbuf[i];
    end
    desel();
  endtask

  task automatic rd(input int a, input int n, input string req);
    logic [7:0] d;
    sel(); xbyte(8'h03, d); send_addr(a);
    for (int i = 0; i < n; i++) begin
      xbyte(8'h00, d);
      chk(d === ref_mem[(a + i) % NB], req, d, ref_mem[(a + i) % NB]);
    end
    desel();
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] s, d;
    tick(5); rst_n = 1'b1; tick(5);
    chk(miso_oe == 1'b0, "reset output enable", miso_oe, 0);
    rdsr(s); chk(s == 8'h00, "R8 reset status", s, 8'h00);
    cmd(8'h06); rdsr(s); chk(s == 8'h02, "R8 latch set", s, 8'h02);
    cmd(8'h04); rdsr(s); chk(s == 8'h00, "R8 latch cleared", s, 8'h00);

    for (int p = 0; p < NB / PG; p++) begin
      mode3 = p[0];
      for (int i = 0; i < PG; i++) wbuf[i] = pat(p * PG + i);
      cmd(8'h06);
      wr(p * PG, PG, 1'b1);
      if (p == 0) begin
        rdsr(s); chk(s == 8'h03, "R9 busy flag during cycle", s, 8'h03);
      end
      wait_idle();
      if (p == 0) begin
        rdsr(s); chk(s == 8'h00, "R8 latch cleared after write", s, 8'h00);
      end
    end

    mode3 = 1'b1;
    rd(NB - 12, NB + 8, "R5 R4 R2 R1 streaming read with wrap");
    mode3 = 1'b0;

    wbuf[0] = 8'h00;
    wr(5, 1, 1'b0);
    rd(5, 1, "R8 write without latch ignored");

    for (int i = 0; i < 18; i++) wbuf[i] = 8'hE0 + 8'(i);
    cmd(8'h06); wr(3 * PG + 14, 18, 1'b1); wait_idle();
    rd(3 * PG, PG, "R7 page wrap overwrite");

    cmd(8'h06);
    sel(); xbyte(8'h02, d); send_addr(100); xbyte(8'h11, d);
    for (int i = 0; i < 3; i++) begin bit r; xbit(1'b1, r); end
    desel();
    rdsr(s); chk(s == 8'h02, "R6 partial byte no cycle", s, 8'h02);
    rd(100, 1, "R6 partial byte discarded");
    sel(); xbyte(8'h02, d); send_addr(101); desel();
    rdsr(s); chk(s == 8'h02, "R6 no data no cycle", s, 8'h02);
    rd(101, 1, "R6 no data unchanged");

    wbuf[0] = 8'h5C; wr(200, 1, 1'b1);
    wbuf[0] = 8'h77; wr(201, 1, 1'b0);
    rdsr(s); chk(s == 8'h03, "R9 busy ignores other opcodes", s, 8'h03);
    wait_idle();
    rd(200, 2, "R9 committed byte and ignored write");

    cmd(8'h06);
    sel(); xbyte(8'hA5, d);
    chk(miso_oe == 1'b0, "R3 unknown opcode output idle", miso_oe, 0);
    xbyte(8'h04, d); desel();
    rdsr(s); chk(s == 8'h02, "R3 bytes after unknown opcode ignored", s, 8'h02);
    cmd(8'h04);

    sel(); xbyte(8'h01, d); xbyte(8'hFF, d); desel();
    rdsr(s); chk(s == 8'h00, "R8 status write needs latch", s, 8'h00);
    cmd(8'h06); sel(); xbyte(8'h01, d); xbyte(8'hFF, d); desel(); wait_idle();
    rdsr(s); chk(s == 8'h8C, "R11 status writable bits", s, 8'h8C);
    cmd(8'h06); sel(); xbyte(8'h01, d); xbyte(8'h00, d); desel(); wait_idle();
    rdsr(s); chk(s == 8'h00, "R11 status bits cleared", s, 8'h00);

    sel(); xbyte(8'h03, d); send_addr(300);
    for (int i = 7; i >= 5; i--) begin bit r; xbit(1'b0, r); d[i] = r; end
    sck = 1'b0; tick(HALF);
    hold_n = 1'b0; tick(4);
    chk(miso_oe == 1'b0, "R10 output released in hold", miso_oe, 0);
    for (int k = 0; k < 2; k++) begin
      sck = 1'b1; mosi = ~mosi; tick(HALF);
      sck = 1'b0; tick(HALF);
    end
    hold_n = 1'b1; tick(4);
    chk(miso_oe == 1'b1, "R10 output back after hold", miso_oe, 1);
    for (int i = 4; i >= 0; i--) begin bit r; xbit(1'b0, r); d[i] = r; end
    chk(d === ref_mem[300], "R10 byte across hold", d, ref_mem[300]);
    xbyte(8'h00, d);
    chk(d === ref_mem[301], "R10 next byte after hold", d, ref_mem[301]);
    desel();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule